// File: doc/BRIEF.md
# Delay-Line Tap Capture and Thermometer Decoder

This block sits behind an external delay chain that carries a delayed reference edge. Each chain stage drives one tap into the block. On every rising edge of the sample clock the block registers all taps at once. The result is a thermometer word: a tap reads 1 when the reference edge has already travelled past that stage, and 0 when it has not.

One cycle later the block turns the captured word into a binary count of the stages the edge has passed. It also raises a flag when the word is not a legal thermometer code. A legal code of value N has its lowest N bits at 1 and every higher bit at 0. A word with a 0 lying beneath a 1 is malformed. For such a word the count still gives the total number of 1 bits, which serves as a bubble-tolerant estimate.

A valid flag marks count outputs that come from a real capture rather than from the reset state. The surrounding logic uses the count as the fine time stamp of the interval between the reference edge and the sample edge.

Top module: `tdc_thermo_capture`

## Requirements
- R1: `therm_q` takes the value of `taps_in` at each rising edge of `clk_sample`, with bit i of the word holding tap i.
- R2: Raising the active-high `rst` clears `therm_q`, `count_q`, `valid_q` and `bubble_q` to zero at once, without waiting for a clock edge.
- R3: At the edge after a capture, `count_q` holds the number of 1 bits in the captured word. For a legal code of value N this number is N.
- R4: `count_q` is ceil(log2(STAGES+1)) bits wide (7 bits for the default of 64 stages). An all-ones word gives a count of STAGES.
- R5: `bubble_q` is 1 exactly when the captured word has some bit i at 0 and bit i+1 at 1. The all-zero word and the all-ones word are legal.
- R6: When the word is malformed (for example 5'b01011 in the low bits), `bubble_q` is 1 and `count_q` equals the total number of 1 bits in the word.
- R7: After `rst` is released, `valid_q` stays 0 through the first rising edge. It becomes 1 at the second edge, which is when the first capture's result appears, and it stays 1 for every edge after that until the next reset.
- R8: `count_q` and `bubble_q` follow `therm_q` with a latency of exactly one sample-clock cycle, including when the taps change on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sample | input | 1 | Sample clock; its rising edge captures the taps |
| rst | input | 1 | Asynchronous active-high reset |
| taps_in | input | STAGES | Tap outputs of the external delay chain |
| therm_q | output | STAGES | Captured thermometer word |
| count_q | output | ceil(log2(STAGES+1)) | Decoded stage count |
| valid_q | output | 1 | Count comes from a real capture |
| bubble_q | output | 1 | Captured word is not a legal thermometer code |

## Verification
The bound checker tests four things on every edge after reset. It checks that the captured word follows the previous tap value, and that the count equals the number of 1 bits in the word captured one cycle earlier. It checks that a clear bubble flag comes only with a word that is exactly the thermometer code of the count, and that a set flag never does. It also checks the valid flag's first-edge and steady-state behaviour.

Some behaviour only the bench scenarios can show. These are the reset clearing the outputs between clock edges, specific boundary words (empty, single stage, full chain, a hole only at the top or bottom), and back-to-back changing taps where each result must line up with its own capture.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    // Default number of delay stages observed by the capture register.
    localparam int DEF_STAGES = 64;

    // Width of a binary count able to hold 0..stages inclusive.
    function automatic int count_width(input int stages);
        return (stages < 1) ? 1 : $clog2(stages + 1);
    endfunction

endpackage

// File: rtl/tdc_tap_capture.sv
module tdc_tap_capture #(
    parameter int STAGES = tdc_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] taps,
    output logic [STAGES-1:0] word_q
);

    // One flop per tap, all sampled on the same clock edge.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= taps;
        end
    end

endmodule

// File: rtl/tdc_therm_decode.sv
module tdc_therm_decode #(
    parameter int STAGES = tdc_pkg::DEF_STAGES,
    localparam int CW    = tdc_pkg::count_width(STAGES)
) (
    input  logic [STAGES-1:0] word,
    output logic [CW-1:0]     ones,
    output logic              bubble
);

    // Population count: equals the code value for a legal word and
    // gives a bubble-tolerant estimate for a malformed one.
    always_comb begin
        ones = '0;
        for (int i = 0; i < STAGES; i++) begin
            ones = ones + CW'(word[i]);
        end
    end

    // A hole is a 0 with a 1 directly above it; any hole breaks the code.
    generate
        if (STAGES > 1) begin : g_holes
            logic [STAGES-2:0] hole;
            for (genvar i = 0; i < STAGES - 1; i++) begin : g_bit
                assign hole[i] = ~word[i] & word[i+1];
            end
            assign bubble = |hole;
        end else begin : g_single
            assign bubble = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/tdc_result_reg.sv
module tdc_result_reg #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] ones,
    input  logic          bubble,
    output logic [CW-1:0] count_q,
    output logic          bubble_q,
    output logic          valid_q
);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          bubble;
        logic          valid;
    } result_t;

    result_t res_q;
    logic    captured_q;   // a real capture sits in the word register

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            res_q      <= '0;
            captured_q <= 1'b0;
        end else begin
            res_q.count  <= ones;
            res_q.bubble <= bubble;
            res_q.valid  <= captured_q;
            captured_q   <= 1'b1;
        end
    end

    assign count_q  = res_q.count;
    assign bubble_q = res_q.bubble;
    assign valid_q  = res_q.valid;

endmodule

// File: rtl/tdc_thermo_capture.sv
module tdc_thermo_capture #(
    parameter int STAGES = tdc_pkg::DEF_STAGES,
    localparam int CW    = tdc_pkg::count_width(STAGES)
) (
    input  logic              clk_sample,
    input  logic              rst,
    input  logic [STAGES-1:0] taps_in,
    output logic [STAGES-1:0] therm_q,
    output logic [CW-1:0]     count_q,
    output logic              valid_q,
    output logic              bubble_q
);

    logic [CW-1:0] dec_ones;
    logic          dec_bubble;

    tdc_tap_capture #(.STAGES(STAGES)) u_capture (
        .clk    (clk_sample),
        .rst    (rst),
        .taps   (taps_in),
        .word_q (therm_q)
    );

    tdc_therm_decode #(.STAGES(STAGES)) u_decode (
        .word   (therm_q),
        .ones   (dec_ones),
        .bubble (dec_bubble)
    );

    tdc_result_reg #(.CW(CW)) u_result (
        .clk      (clk_sample),
        .rst      (rst),
        .ones     (dec_ones),
        .bubble   (dec_bubble),
        .count_q  (count_q),
        .bubble_q (bubble_q),
        .valid_q  (valid_q)
    );

endmodule

// File: rtl/tdc_thermo_checker.sv
module tdc_thermo_checker #(
    parameter int STAGES = tdc_pkg::DEF_STAGES,
    localparam int CW    = tdc_pkg::count_width(STAGES)
) (
    input logic              clk_sample,
    input logic              rst,
    input logic [STAGES-1:0] taps_in,
    input logic [STAGES-1:0] therm_q,
    input logic [CW-1:0]     count_q,
    input logic              valid_q,
    input logic              bubble_q
);

    // Edges seen since reset release: seen1 after one, seen2 after two.
    logic seen1, seen2;
    always_ff @(posedge clk_sample or posedge rst) begin
        if (rst) begin
            seen1 <= 1'b0;
            seen2 <= 1'b0;
        end else begin
            seen1 <= 1'b1;
            seen2 <= seen1;
        end
    end

    function automatic logic [STAGES-1:0] therm_of(input int n);
        logic [STAGES-1:0] w;
        for (int i = 0; i < STAGES; i++) w[i] = (i < n);
        return w;
    endfunction

    a_r1_capture: assert property (@(posedge clk_sample) disable iff (rst)
        seen1 |-> therm_q == $past(taps_in));

    a_r3_count_ones: assert property (@(posedge clk_sample) disable iff (rst)
        seen1 |-> int'(count_q) == $countones($past(therm_q)));

    a_r4_count_range: assert property (@(posedge clk_sample) disable iff (rst)
        int'(count_q) <= STAGES);

    a_r5_legal_matches_count: assert property (@(posedge clk_sample) disable iff (rst)
        (seen1 && !bubble_q) |-> $past(therm_q) == therm_of(int'(count_q)));

    a_r6_bubble_not_legal: assert property (@(posedge clk_sample) disable iff (rst)
        (seen1 && bubble_q) |-> $past(therm_q) != therm_of(int'(count_q)));

    a_r7_valid_steady: assert property (@(posedge clk_sample) disable iff (rst)
        seen2 |-> valid_q);

    a_r7_valid_first: assert property (@(posedge clk_sample) disable iff (rst)
        !seen2 |-> !valid_q);

    // R2: while reset is held every output sits at zero.
    always @(negedge clk_sample) begin
        if (rst) begin
            a_r2_reset_clear: assert (therm_q == '0 && count_q == '0 &&
                                      !valid_q && !bubble_q);
        end
    end

endmodule

bind tdc_thermo_capture tdc_thermo_checker #(.STAGES(STAGES)) u_chk (
    .clk_sample (clk_sample),
    .rst        (rst),
    .taps_in    (taps_in),
    .therm_q    (therm_q),
    .count_q    (count_q),
    .valid_q    (valid_q),
    .bubble_q   (bubble_q)
);

// File: tb/tdc_thermo_capture_bench.sv
module tdc_thermo_capture_bench;

    localparam int STAGES = 64;
    localparam int CW     = 7;

    logic              clk_sample = 1'b0;
    logic              rst = 1'b0;
    logic [STAGES-1:0] taps_in = '0;
    logic [STAGES-1:0] therm_q;
    logic [CW-1:0]     count_q;
    logic              valid_q;
    logic              bubble_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk_sample = ~clk_sample;   // 200 MHz

    tdc_thermo_capture #(.STAGES(STAGES)) u_tdc_thermo_capture (
        .clk_sample (clk_sample),
        .rst        (rst),
        .taps_in    (taps_in),
        .therm_q    (therm_q),
        .count_q    (count_q),
        .valid_q    (valid_q),
        .bubble_q   (bubble_q)
    );

    function automatic logic [STAGES-1:0] therm(input int n);
        logic [STAGES-1:0] w;
        for (int i = 0; i < STAGES; i++) w[i] = (i < n);
        return w;
    endfunction

    function automatic int ones_of(input logic [STAGES-1:0] w);
        int c = 0;
        for (int i = 0; i < STAGES; i++) c += int'(w[i]);
        return c;
    endfunction

    function automatic bit has_hole(input logic [STAGES-1:0] w);
        bit zero_below = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            if (w[i] && zero_below) return 1'b1;
            if (!w[i]) zero_below = 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [STAGES-1:0] act, input logic [STAGES-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_sample);
        rst = 1'b1;
        @(negedge clk_sample);
        @(negedge clk_sample);
        rst = 1'b0;
    endtask

    // Apply one word and check capture then decoded result (R1, R3, R5, R8).
    task automatic sample_word(input string req, input logic [STAGES-1:0] w);
        taps_in = w;
        @(negedge clk_sample);
        check(req, "therm_q", therm_q, w);
        taps_in = '0;
        @(negedge clk_sample);
        check(req, "count_q", STAGES'(count_q), STAGES'(ones_of(w)));
        check(req, "bubble_q", STAGES'(bubble_q), STAGES'(has_hole(w)));
    endtask

    task automatic t_reset_state();
        // R2: outputs zero right after reset, before any capture
        check("R2", "therm_q", therm_q, '0);
        check("R2", "count_q", STAGES'(count_q), '0);
        check("R2", "valid_q", STAGES'(valid_q), '0);
        check("R2", "bubble_q", STAGES'(bubble_q), '0);
    endtask

    task automatic t_valid_start();
        // R7: low after the first edge, high from the second edge on
        do_reset();
        taps_in = therm(3);
        @(negedge clk_sample);
        check("R7", "valid after first edge", STAGES'(valid_q), '0);
        @(negedge clk_sample);
        check("R7", "valid after second edge", STAGES'(valid_q), 1);
        check("R7", "count of first capture", STAGES'(count_q), 3);
        @(negedge clk_sample);
        check("R7", "valid stays high", STAGES'(valid_q), 1);
    endtask

    task automatic t_legal_codes();
        sample_word("R3", therm(0));
        sample_word("R3", therm(1));
        sample_word("R3", therm(7));
        sample_word("R3", therm(33));
        sample_word("R3", therm(63));
        sample_word("R4", therm(64));   // full chain -> 64 in 7 bits
        check("R4", "full count", STAGES'(count_q), 64);
        check("R5", "full is legal", STAGES'(bubble_q), 0);
    endtask

    task automatic t_bubbles();
        sample_word("R6", 64'b01011);
        check("R6", "01011 count", STAGES'(count_q), 3);
        check("R6", "01011 flag", STAGES'(bubble_q), 1);
        sample_word("R5", 64'h8000_0000_0000_0000);          // top bit alone
        sample_word("R5", 64'hFFFF_FFFF_FFFF_FFFE);          // hole at bit 0
        sample_word("R6", 64'h0000_00F0_0000_FFFF);
        sample_word("R5", 64'hAAAA_AAAA_AAAA_AAAA);
    endtask

    task automatic t_back_to_back();
        // R8: a new word every edge; each result trails its capture by one
        logic [STAGES-1:0] prev;
        taps_in = therm(10);
        @(negedge clk_sample);
        prev = therm_q;
        for (int k = 0; k < 6; k++) begin
            taps_in = (k % 2 == 0) ? therm(5 * k + 20) : (therm(12) | 64'h1 << (40 + k));
            @(negedge clk_sample);
            check("R8", "count lags word", STAGES'(count_q), STAGES'(ones_of(prev)));
            check("R8", "bubble lags word", STAGES'(bubble_q), STAGES'(has_hole(prev)));
            check("R1", "word tracks taps", therm_q, taps_in);
            prev = therm_q;
        end
    endtask

    task automatic t_async_reset();
        // R2: reset raised mid-cycle clears outputs before any edge
        taps_in = therm(40);
        @(negedge clk_sample);
        @(negedge clk_sample);
        #0.5 rst = 1'b1;
        #0.5;
        check("R2", "async therm_q", therm_q, '0);
        check("R2", "async count_q", STAGES'(count_q), '0);
        check("R2", "async valid_q", STAGES'(valid_q), '0);
        @(negedge clk_sample);
        rst = 1'b0;
        taps_in = '0;
    endtask

    initial begin
        #1 rst = 1'b1;
        @(negedge clk_sample);
        @(negedge clk_sample);
        t_reset_state();
        rst = 1'b0;
        t_valid_start();
        t_legal_codes();
        t_bubbles();
        t_back_to_back();
        t_async_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk_sample);
                failures++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule